// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit data pointers for an 8051-class processor core and chooses which of them is active through a select bit. The core reaches the pointers through special-function-register (SFR) byte accesses. The block decodes four fixed byte addresses: the low byte of the active pointer, its high byte, a select register, and an auxiliary control register.

The core also drives pointer operations straight into the block. It can load a 16-bit immediate into the active pointer or increment it by one. The active pointer is always presented as an address for external-data moves, code-table reads and indirect jumps.

The select register holds the select bit and one user flag. Its bit 2 is tied to zero. Because of this, a read-modify-write increment of the whole register flips the select bit and never carries into the flag. The auxiliary register holds two control bits:

- one suppresses the address-latch-enable strobe;
- one routes data accesses to external RAM.

Top module: `dptr_sfr_unit`

## Requirements
- R1: After a synchronous reset both pointers are 0000h, the select bit and the flag are 0 (pointer 0 active), and both auxiliary bits are 0.
- R2: With `ptr_op` = 2'b01 the active pointer takes the value of `ptr_imm` at the next clock edge, and the inactive pointer keeps its value.
- R3: With `ptr_op` = 2'b10 the active pointer increments by one at the next clock edge and wraps from FFFFh to 0000h, and the inactive pointer keeps its value. Codes 2'b00 and 2'b11 leave both pointers unchanged.
- R4: `ptr_addr` always shows the full 16-bit value of the currently selected pointer.
- R5: SFR address 82h reads and writes bits 7:0 of the active pointer, and address 83h reads and writes bits 15:8. A byte write changes only its own byte, from the next edge on.
- R6: The select register at address A2h reads as {4'b0000, flag, 1'b0, 1'b0, sel}. A write stores bit 0 into sel and bit 3 into flag, and bits 1, 2 and 4 to 7 are ignored.
- R7: Writing back the value read from A2h plus one toggles sel and leaves flag unchanged.
- R8: The auxiliary register at address 8Eh reads as {6'b0, ext_ram_en, ale_disable}. A write stores bit 0 into `ale_disable` and bit 1 into `ext_ram_en`.
- R9: When an SFR byte write to 82h or 83h and a load or increment fall in the same cycle, the core operation decides the active pointer's new value. An SFR read in that cycle returns the value from before the update.
- R10: Any other SFR address reads as 00h, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR byte address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` (combinational) |
| ptr_op | input | 2 | Pointer operation: 00 idle, 01 load, 10 increment, 11 idle |
| ptr_imm | input | 16 | Immediate value for a load |
| ptr_addr | output | 16 | Active pointer value |
| dptr_sel | output | 1 | Current select bit |
| ale_disable | output | 1 | Address-latch-enable suppress |
| ext_ram_en | output | 1 | External RAM select |

## Verification
Every register write, pointer load and increment becomes visible on `ptr_addr`, `dptr_sel`, the auxiliary outputs and `sfr_rdata` one clock edge after the cycle that presents it. SFR reads are combinational on the current state, so they reflect the old value up to that edge.

The bench changes inputs 2 ns after a rising edge and samples outputs at that same offset after the following edge. Each update is therefore seen exactly one cycle after its stimulus. The same-cycle conflict checks read the affected byte before that edge, to confirm the pre-update value, and check the pointer after it.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ADDR_PTR_LO = 8'h82;
    localparam logic [BYTE_W-1:0] ADDR_PTR_HI = 8'h83;
    localparam logic [BYTE_W-1:0] ADDR_AUX    = 8'h8E;
    localparam logic [BYTE_W-1:0] ADDR_SEL    = 8'hA2;

    // bit positions inside the byte-wide registers
    localparam int SEL_BIT  = 0;
    localparam int FLAG_BIT = 3;
    localparam int ALE_BIT  = 0;
    localparam int XRAM_BIT = 1;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_LOAD = 2'b01,
        OP_INC  = 2'b10,
        OP_RSVD = 2'b11
    } ptr_op_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic sel;
        logic aux;
    } sfr_hit_t;

    typedef struct packed {
        logic flag;
        logic sel;
    } sel_reg_t;

    typedef struct packed {
        logic ext_ram;
        logic ale_off;
    } aux_reg_t;

    function automatic sfr_hit_t decode_addr(input logic [BYTE_W-1:0] a);
        sfr_hit_t h;
        h.lo  = (a == ADDR_PTR_LO);
        h.hi  = (a == ADDR_PTR_HI);
        h.sel = (a == ADDR_SEL);
        h.aux = (a == ADDR_AUX);
        return h;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_sel(input sel_reg_t r);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[SEL_BIT]  = r.sel;
        b[FLAG_BIT] = r.flag;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_aux(input aux_reg_t r);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[ALE_BIT]  = r.ale_off;
        b[XRAM_BIT] = r.ext_ram;
        return b;
    endfunction

endpackage

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int PTR_W    = 16,
    parameter int NUM_PTRS = 2,
    localparam int SEL_W   = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1,
    localparam int HI_W    = PTR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  ptr_op_e           op,
    input  logic [PTR_W-1:0]  imm,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  cur_ptr
);

    logic [PTR_W-1:0] ptr_q [NUM_PTRS];

    for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
        logic active;
        assign active = (sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[i] <= '0;
            end else if (active) begin
                // a core operation takes priority over an SFR byte write
                unique case (op)
                    OP_LOAD: ptr_q[i] <= imm;
                    OP_INC:  ptr_q[i] <= ptr_q[i] + PTR_W'(1);
                    default: begin
                        if (we_lo) ptr_q[i][BYTE_W-1:0]     <= wdata;
                        if (we_hi) ptr_q[i][PTR_W-1:BYTE_W] <= wdata[HI_W-1:0];
                    end
                endcase
            end
        end
    end

    assign cur_ptr = ptr_q[sel];

endmodule

// File: rtl/dptr_ctrl_regs.sv
module dptr_ctrl_regs
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_sel,
    input  logic              we_aux,
    input  logic [BYTE_W-1:0] wdata,
    output sel_reg_t          sel_q,
    output aux_reg_t          aux_q
);

    // only the implemented bits are captured; bit 2 and the rest are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (we_sel) begin
            sel_q.sel  <= wdata[SEL_BIT];
            sel_q.flag <= wdata[FLAG_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_q <= '0;
        end else if (we_aux) begin
            aux_q.ale_off <= wdata[ALE_BIT];
            aux_q.ext_ram <= wdata[XRAM_BIT];
        end
    end

endmodule

// File: rtl/dptr_sfr_unit.sv
module dptr_sfr_unit
    import dptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       sfr_addr,
    input  logic             sfr_we,
    input  logic [7:0]       sfr_wdata,
    output logic [7:0]       sfr_rdata,
    input  logic [1:0]       ptr_op,
    input  logic [PTR_W-1:0] ptr_imm,
    output logic [PTR_W-1:0] ptr_addr,
    output logic             dptr_sel,
    output logic             ale_disable,
    output logic             ext_ram_en
);

    localparam int NUM_PTRS = 2;
    localparam int HI_W     = PTR_W - BYTE_W;

    sfr_hit_t   hit;
    sel_reg_t   sel_q;
    aux_reg_t   aux_q;
    ptr_op_e    op;
    logic [PTR_W-1:0] cur_ptr;

    assign hit = decode_addr(sfr_addr);
    assign op  = ptr_op_e'(ptr_op);

    dptr_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .we_sel (sfr_we & hit.sel),
        .we_aux (sfr_we & hit.aux),
        .wdata  (sfr_wdata),
        .sel_q  (sel_q),
        .aux_q  (aux_q)
    );

    dptr_bank #(
        .PTR_W    (PTR_W),
        .NUM_PTRS (NUM_PTRS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_q.sel),
        .op      (op),
        .imm     (ptr_imm),
        .we_lo   (sfr_we & hit.lo),
        .we_hi   (sfr_we & hit.hi),
        .wdata   (sfr_wdata),
        .cur_ptr (cur_ptr)
    );

    always_comb begin
        sfr_rdata = '0;
        if (hit.lo)  sfr_rdata = cur_ptr[BYTE_W-1:0];
        if (hit.hi)  sfr_rdata = BYTE_W'(cur_ptr[PTR_W-1:BYTE_W]);
        if (hit.sel) sfr_rdata = pack_sel(sel_q);
        if (hit.aux) sfr_rdata = pack_aux(aux_q);
    end

    assign ptr_addr    = cur_ptr;
    assign dptr_sel    = sel_q.sel;
    assign ale_disable = aux_q.ale_off;
    assign ext_ram_en  = aux_q.ext_ram;

endmodule

// File: rtl/dptr_sfr_checker.sv
module dptr_sfr_checker (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  sfr_addr,
    input logic        sfr_we,
    input logic [7:0]  sfr_wdata,
    input logic [7:0]  sfr_rdata,
    input logic [1:0]  ptr_op,
    input logic [15:0] ptr_imm,
    input logic [15:0] ptr_addr,
    input logic        dptr_sel,
    input logic        ale_disable,
    input logic        ext_ram_en
);

    logic sel_wr;
    assign sel_wr = sfr_we && (sfr_addr == 8'hA2);

    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (ptr_addr == 16'h0000 && !dptr_sel && !ale_disable && !ext_ram_en));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (ptr_op == 2'b01 && !sel_wr) |=> (ptr_addr == $past(ptr_imm)));

    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (ptr_op == 2'b10 && !sel_wr) |=> (ptr_addr == $past(ptr_addr) + 16'd1));

    assert_lo_write_R5: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && sfr_addr == 8'h82 && ptr_op[0] == ptr_op[1]) |=>
        (ptr_addr == {$past(ptr_addr[15:8]), $past(sfr_wdata)}));

    assert_sel_read_R6: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == 8'hA2) |-> (sfr_rdata[7:4] == 4'h0 && sfr_rdata[2:1] == 2'b00
                                 && sfr_rdata[0] == dptr_sel));

    assert_aux_read_R8: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == 8'h8E) |-> (sfr_rdata == {6'b0, ext_ram_en, ale_disable}));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst)
        (sfr_we && sfr_addr == 8'h40 && ptr_op[0] == ptr_op[1]) |=>
        ($stable(ptr_addr) && $stable(dptr_sel) && $stable(ale_disable) && $stable(ext_ram_en)));

endmodule

bind dptr_sfr_unit dptr_sfr_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .sfr_addr    (sfr_addr),
    .sfr_we      (sfr_we),
    .sfr_wdata   (sfr_wdata),
    .sfr_rdata   (sfr_rdata),
    .ptr_op      (ptr_op),
    .ptr_imm     (ptr_imm),
    .ptr_addr    (ptr_addr),
    .dptr_sel    (dptr_sel),
    .ale_disable (ale_disable),
    .ext_ram_en  (ext_ram_en)
);

// File: tb/dptr_sfr_unit_test.sv
`timescale 1ns/1ps
module dptr_sfr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [1:0]  ptr_op = 2'b00;
    logic [15:0] ptr_imm = 16'h0000;
    logic [15:0] ptr_addr;
    logic        dptr_sel;
    logic        ale_disable;
    logic        ext_ram_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dptr_sfr_unit uut (
        .clk(clk), .rst(rst),
        .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .ptr_op(ptr_op), .ptr_imm(ptr_imm), .ptr_addr(ptr_addr),
        .dptr_sel(dptr_sel), .ale_disable(ale_disable), .ext_ram_en(ext_ram_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        tick();
        sfr_we = 1'b0; sfr_addr = 8'h00;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
        sfr_addr = 8'h00;
    endtask

    task automatic core_op(input logic [1:0] op, input logic [15:0] imm);
        ptr_op = op; ptr_imm = imm;
        tick();
        ptr_op = 2'b00;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ptr", ptr_addr, 16'h0000);
        check("R1 sel", dptr_sel, 1'b0);
        check("R1 aux", {ext_ram_en, ale_disable}, 2'b00);
        sfr_read(8'hA2, d);
        check("R1 selreg", d, 8'h00);
    endtask

    task automatic t_load();
        core_op(2'b01, 16'h1234);
        check("R2 load ptr0", ptr_addr, 16'h1234);
        sfr_write(8'hA2, 8'h01);
        check("R4 ptr1 untouched", ptr_addr, 16'h0000);
        core_op(2'b01, 16'hBEEF);
        check("R2 load ptr1", ptr_addr, 16'hBEEF);
        sfr_write(8'hA2, 8'h00);
        check("R2 ptr0 kept", ptr_addr, 16'h1234);
    endtask

    task automatic t_inc();
        core_op(2'b10, 16'h0000);
        check("R3 inc", ptr_addr, 16'h1235);
        core_op(2'b11, 16'hFFFF);
        check("R3 rsvd idle", ptr_addr, 16'h1235);
        core_op(2'b00, 16'hFFFF);
        check("R3 idle", ptr_addr, 16'h1235);
        sfr_write(8'hA2, 8'h01);
        core_op(2'b01, 16'hFFFF);
        core_op(2'b10, 16'h0000);
        check("R3 wrap", ptr_addr, 16'h0000);
        sfr_write(8'hA2, 8'h00);
        check("R3 other kept", ptr_addr, 16'h1235);
    endtask

    task automatic t_bytes();
        logic [7:0] d;
        sfr_read(8'h82, d);
        check("R5 read lo", d, 8'h35);
        sfr_read(8'h83, d);
        check("R5 read hi", d, 8'h12);
        sfr_write(8'h82, 8'hA5);
        check("R5 write lo", ptr_addr, 16'h12A5);
        sfr_write(8'h83, 8'h5A);
        check("R5 write hi", ptr_addr, 16'h5AA5);
        sfr_write(8'hA2, 8'h01);
        sfr_read(8'h83, d);
        check("R5 hi of ptr1", d, 8'h00);
        sfr_write(8'hA2, 8'h00);
    endtask

    task automatic t_select();
        logic [7:0] d;
        sfr_write(8'hA2, 8'hFE);
        sfr_read(8'hA2, d);
        check("R6 masked write", d, 8'h08);
        check("R6 sel", dptr_sel, 1'b0);
        sfr_write(8'hA2, 8'h04);
        sfr_read(8'hA2, d);
        check("R6 bit2 ignored", d, 8'h00);
    endtask

    task automatic t_rmw();
        logic [7:0] d;
        sfr_write(8'hA2, 8'h08);
        sfr_read(8'hA2, d);
        sfr_write(8'hA2, d + 8'd1);
        sfr_read(8'hA2, d);
        check("R7 toggle to 1", d, 8'h09);
        sfr_write(8'hA2, d + 8'd1);
        sfr_read(8'hA2, d);
        check("R7 toggle to 0 flag kept", d, 8'h08);
        check("R7 sel pin", dptr_sel, 1'b0);
        sfr_write(8'hA2, 8'h00);
    endtask

    task automatic t_aux();
        logic [7:0] d;
        sfr_write(8'h8E, 8'hFD);
        check("R8 ale", {ext_ram_en, ale_disable}, 2'b01);
        sfr_read(8'h8E, d);
        check("R8 read", d, 8'h01);
        sfr_write(8'h8E, 8'h02);
        check("R8 xram", {ext_ram_en, ale_disable}, 2'b10);
    endtask

    task automatic t_conflict();
        logic [7:0] d;
        // active pointer 0 holds 5AA5h
        sfr_addr = 8'h82; sfr_wdata = 8'hCC; sfr_we = 1'b1;
        ptr_op = 2'b01; ptr_imm = 16'h7788;
        #1;
        check("R9 old read", sfr_rdata, 8'hA5);
        tick();
        sfr_we = 1'b0; ptr_op = 2'b00; sfr_addr = 8'h00;
        check("R9 load wins", ptr_addr, 16'h7788);
        sfr_addr = 8'h83; sfr_wdata = 8'h11; sfr_we = 1'b1; ptr_op = 2'b10;
        tick();
        sfr_we = 1'b0; ptr_op = 2'b00; sfr_addr = 8'h00;
        check("R9 inc wins", ptr_addr, 16'h7789);
        sfr_read(8'h83, d);
        check("R9 hi kept", d, 8'h77);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        sfr_write(8'h40, 8'hFF);
        check("R10 ptr", ptr_addr, 16'h7789);
        check("R10 ctrl", {ext_ram_en, ale_disable, dptr_sel}, 3'b100);
        sfr_read(8'h40, d);
        check("R10 read", d, 8'h00);
        sfr_read(8'h84, d);
        check("R10 read neighbour", d, 8'h00);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_load();
        t_inc();
        t_bytes();
        t_select();
        t_rmw();
        t_aux();
        t_conflict();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule